// File: doc/BRIEF.md
# Floating-Point Compare Unit

This unit compares two IEEE-754 double-precision operands and reduces the outcome to a one-hot, four-bit condition code. On every accepted compare, the code goes to two places. It is written into one of eight four-bit fields of a condition register, chosen by a three-bit index. It is also loaded into a four-bit result-class field of the floating-point status.

A mode input picks one of two compare modes. In unordered mode, only signaling NaNs raise an exception flag. In ordered mode, an unordered result also raises a flag when its NaN inputs are quiet. The condition code is written whether or not an exception flag is raised in the same compare. Trap delivery, enable masking and instruction decode are handled elsewhere.

All results are registered and appear one clock after the valid strobe. They hold until the next accepted compare.

Top module: `fp_compare_unit`

## Requirements
- R1: Every compare yields exactly one condition-code bit: less = 4'b1000, greater = 4'b0100, equal = 4'b0010, unordered = 4'b0001.
- R2: An operand is a NaN when its exponent bits [62:52] are all ones and its fraction bits [51:0] are nonzero. If either operand is a NaN, the code is unordered and no magnitude ordering is applied.
- R3: Non-NaN operands are ordered as real numbers. +0 and -0 are equal, infinities are the extreme values, and subnormals order above zero by sign. Greater is reported when the first operand is neither less than nor equal to the second.
- R4: Condition-register field k occupies bits [4k+3:4k] of `cr_value` and receives the code when `dst_field` = k. All other fields keep their values.
- R5: The result-class output `fpsr_class` is overwritten with the same code on every compare.
- R6: In both modes, a signaling NaN in either operand raises `flag_snan`. A NaN is signaling when fraction bit 51 is 0 and quiet when that bit is 1.
- R7: In ordered mode (`cmp_ordered` = 1), an unordered result whose NaN inputs are all quiet raises `flag_vc` and leaves `flag_snan` clear.
- R8: In unordered mode (`cmp_ordered` = 0), quiet NaN inputs raise no flag.
- R9: The condition-register field and the result class are written even when a flag is raised by the same compare.
- R10: Outputs update one clock after `cmp_valid` is high. While `cmp_valid` is low, the outputs hold.
- R11: While `rst_n` is low, the condition register, the result class and both flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_valid | input | 1 | Accept a compare this cycle |
| cmp_ordered | input | 1 | 1 = ordered mode, 0 = unordered mode |
| dst_field | input | 3 | Index of the condition-register field to write |
| opnd_a | input | 64 | First double-precision operand |
| opnd_b | input | 64 | Second double-precision operand |
| cr_value | output | 32 | Eight four-bit condition-register fields |
| fpsr_class | output | 4 | Result-class field of the status |
| flag_snan | output | 1 | Invalid operation: signaling NaN input |
| flag_vc | output | 1 | Invalid operation: ordered compare of quiet NaN |

## Verification
The condition-code write and the raising of an invalid-operation flag fall in the same cycle. The vector table provokes this with signaling NaNs in either operand and in both modes, with quiet NaNs in ordered mode, and with a mix of a quiet and a signaling NaN. For each such compare, the bench samples the selected field, the result class and both flags together at the cycle after the strobe. It judges all four against a reference built from real-valued comparison and bit-level NaN classification.

// File: rtl/fp_compare_unit.sv
module fp_compare_unit #(
  parameter int FIELDS = 8,
  parameter int DW     = 64,
  parameter int EXPW   = 11,
  localparam int FW    = 4,
  localparam int FRACW = DW - EXPW - 1,
  localparam int IDXW  = $clog2(FIELDS),
  localparam int CRW   = FIELDS * FW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmp_valid,
  input  logic            cmp_ordered,
  input  logic [IDXW-1:0] dst_field,
  input  logic [DW-1:0]   opnd_a,
  input  logic [DW-1:0]   opnd_b,
  output logic [CRW-1:0]  cr_value,
  output logic [FW-1:0]   fpsr_class,
  output logic            flag_snan,
  output logic            flag_vc
);

  localparam logic [FW-1:0] CC_LT = 4'b1000;
  localparam logic [FW-1:0] CC_GT = 4'b0100;
  localparam logic [FW-1:0] CC_EQ = 4'b0010;
  localparam logic [FW-1:0] CC_UN = 4'b0001;

  wire            sgn_a = opnd_a[DW-1];
  wire            sgn_b = opnd_b[DW-1];
  wire [DW-2:0]   mag_a = opnd_a[DW-2:0];
  wire [DW-2:0]   mag_b = opnd_b[DW-2:0];
  wire [FRACW-1:0] frc_a = opnd_a[FRACW-1:0];
  wire [FRACW-1:0] frc_b = opnd_b[FRACW-1:0];

  wire nan_a  = (&opnd_a[DW-2 -: EXPW]) && (|frc_a);
  wire nan_b  = (&opnd_b[DW-2 -: EXPW]) && (|frc_b);
  wire snan_a = nan_a && !frc_a[FRACW-1];
  wire snan_b = nan_b && !frc_b[FRACW-1];

  wire unord     = nan_a || nan_b;
  wire both_zero = ~|mag_a && ~|mag_b;
  wire is_eq     = both_zero || (opnd_a == opnd_b);

  logic is_lt;
  always_comb begin
    if (both_zero)          is_lt = 1'b0;
    else if (sgn_a != sgn_b) is_lt = sgn_a;
    else if (!sgn_a)        is_lt = mag_a < mag_b;
    else                    is_lt = mag_a > mag_b;
  end

  logic [FW-1:0] code;
  always_comb begin
    if (unord)      code = CC_UN;
    else if (is_lt) code = CC_LT;
    else if (is_eq) code = CC_EQ;
    else            code = CC_GT;
  end

  wire raise_snan = snan_a || snan_b;
  wire raise_vc   = cmp_ordered && unord && !raise_snan;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cr_value   <= '0;
      fpsr_class <= '0;
      flag_snan  <= 1'b0;
      flag_vc    <= 1'b0;
    end else if (cmp_valid) begin
      cr_value[dst_field*FW +: FW] <= code;
      fpsr_class <= code;
      flag_snan  <= raise_snan;
      flag_vc    <= raise_vc;
    end
  end

endmodule

// File: rtl/fp_compare_unit_chk.sv
module fp_compare_unit_chk #(
  parameter int FIELDS = 8,
  localparam int FW    = 4,
  localparam int IDXW  = $clog2(FIELDS),
  localparam int CRW   = FIELDS * FW
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmp_valid,
  input logic            cmp_ordered,
  input logic [IDXW-1:0] dst_field,
  input logic [CRW-1:0]  cr_value,
  input logic [FW-1:0]   fpsr_class,
  input logic            flag_snan,
  input logic            flag_vc
);

  assert_onehot_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmp_valid) |-> $countones(fpsr_class) == 1);

  assert_field_matches_class_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmp_valid) |-> cr_value[$past(dst_field)*FW +: FW] == fpsr_class);

  assert_hold_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!cmp_valid) |-> ($stable(cr_value) && $stable(fpsr_class) &&
                           $stable(flag_snan) && $stable(flag_vc)));

  assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(flag_snan && flag_vc));

  assert_flag_written_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_snan || flag_vc) |-> fpsr_class == 4'b0001);

  assert_no_vc_unordered_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmp_valid && !cmp_ordered) |-> !flag_vc);

endmodule

bind fp_compare_unit fp_compare_unit_chk #(.FIELDS(FIELDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_ordered(cmp_ordered),
  .dst_field(dst_field), .cr_value(cr_value), .fpsr_class(fpsr_class),
  .flag_snan(flag_snan), .flag_vc(flag_vc)
);

// File: tb/test_fp_compare_unit.sv
module test_fp_compare_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmp_valid = 1'b0;
  logic        cmp_ordered = 1'b0;
  logic [2:0]  dst_field = '0;
  logic [63:0] opnd_a = '0;
  logic [63:0] opnd_b = '0;
  logic [31:0] cr_value;
  logic [3:0]  fpsr_class;
  logic        flag_snan, flag_vc;

  int n_checks = 0;
  int n_fails  = 0;

  always #2 clk = ~clk;

  fp_compare_unit i_fp_compare_unit (
    .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_ordered(cmp_ordered),
    .dst_field(dst_field), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .cr_value(cr_value), .fpsr_class(fpsr_class),
    .flag_snan(flag_snan), .flag_vc(flag_vc)
  );

  localparam logic [63:0] P1   = 64'h3FF0_0000_0000_0000;
  localparam logic [63:0] P2   = 64'h4000_0000_0000_0000;
  localparam logic [63:0] M1   = 64'hBFF0_0000_0000_0000;
  localparam logic [63:0] M2   = 64'hC000_0000_0000_0000;
  localparam logic [63:0] PZ   = 64'h0000_0000_0000_0000;
  localparam logic [63:0] MZ   = 64'h8000_0000_0000_0000;
  localparam logic [63:0] PINF = 64'h7FF0_0000_0000_0000;
  localparam logic [63:0] MINF = 64'hFFF0_0000_0000_0000;
  localparam logic [63:0] QNAN = 64'h7FF8_0000_0000_0000;
  localparam logic [63:0] MQN  = 64'hFFF8_0000_0000_0001;
  localparam logic [63:0] SNAN = 64'h7FF0_0000_0000_0001;
  localparam logic [63:0] DEN  = 64'h0000_0000_0000_0001;

  typedef struct packed {
    logic [63:0] a;
    logic [63:0] b;
    logic        ord;
    logic [2:0]  fld;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{P1,   P2,   1'b0, 3'd0},
    '{P2,   P1,   1'b0, 3'd1},
    '{P1,   P1,   1'b1, 3'd2},
    '{PZ,   MZ,   1'b0, 3'd3},
    '{M1,   P1,   1'b1, 3'd4},
    '{M2,   M1,   1'b0, 3'd5},
    '{PINF, P2,   1'b1, 3'd6},
    '{MINF, M2,   1'b0, 3'd7},
    '{QNAN, P1,   1'b0, 3'd0},
    '{P1,   QNAN, 1'b1, 3'd1},
    '{SNAN, P1,   1'b0, 3'd2},
    '{P1,   SNAN, 1'b1, 3'd3},
    '{QNAN, SNAN, 1'b1, 3'd4},
    '{MQN,  MINF, 1'b0, 3'd5},
    '{DEN,  PZ,   1'b1, 3'd6},
    '{PINF, PINF, 1'b0, 3'd7}
  };

  function automatic logic is_nan(input logic [63:0] v);
    return (v[62:52] == 11'h7FF) && (v[51:0] != '0);
  endfunction

  function automatic logic is_snan(input logic [63:0] v);
    return is_nan(v) && !v[51];
  endfunction

  function automatic logic [3:0] ref_code(input logic [63:0] a, input logic [63:0] b);
    real ra, rb;
    if (is_nan(a) || is_nan(b)) return 4'b0001;
    ra = $bitstoreal(a);
    rb = $bitstoreal(b);
    if (ra < rb)  return 4'b1000;
    if (ra == rb) return 4'b0010;
    return 4'b0100;
  endfunction

  task automatic check(input logic ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_compare(input logic [63:0] a, input logic [63:0] b,
                            input logic ord, input logic [2:0] fld);
    opnd_a = a; opnd_b = b; cmp_ordered = ord; dst_field = fld; cmp_valid = 1'b1;
    @(negedge clk);
    cmp_valid = 1'b0;
  endtask

  logic [31:0] exp_cr = '0;

  initial begin
    #100000;
    n_fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(cr_value == '0 && fpsr_class == '0 && !flag_snan && !flag_vc, "R11 reset",
          {flag_snan, flag_vc, fpsr_class, cr_value}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [3:0] c;
      logic es, ev;
      c  = ref_code(VEC[i].a, VEC[i].b);
      es = is_snan(VEC[i].a) || is_snan(VEC[i].b);
      ev = VEC[i].ord && (c == 4'b0001) && !es;
      exp_cr[VEC[i].fld*4 +: 4] = c;
      do_compare(VEC[i].a, VEC[i].b, VEC[i].ord, VEC[i].fld);
      check(fpsr_class == c, "R1 R2 R3 R5 code", {60'd0, fpsr_class}, {60'd0, c});
      check(cr_value == exp_cr, "R4 R9 field write", {32'd0, cr_value}, {32'd0, exp_cr});
      check(flag_snan == es, "R6 snan flag", {63'd0, flag_snan}, {63'd0, es});
      check(flag_vc == ev, "R7 R8 vc flag", {63'd0, flag_vc}, {63'd0, ev});
    end

    // R10: inputs change without strobe, outputs hold
    opnd_a = SNAN; opnd_b = QNAN; cmp_ordered = 1'b1; dst_field = 3'd2;
    repeat (3) @(negedge clk);
    check(cr_value == exp_cr && fpsr_class == 4'b0010 && !flag_snan && !flag_vc,
          "R10 hold", {28'd0, fpsr_class, cr_value}, {28'd0, 4'b0010, exp_cr});

    // R7: negative quiet NaN in ordered mode
    exp_cr[3*4 +: 4] = 4'b0001;
    do_compare(P2, MQN, 1'b1, 3'd3);
    check(flag_vc && !flag_snan && cr_value == exp_cr, "R7 R9 ordered qnan",
          {30'd0, flag_vc, flag_snan, cr_value}, {30'd0, 2'b10, exp_cr});

    // R3: subnormal negative vs negative zero
    exp_cr[0 +: 4] = 4'b1000;
    do_compare({1'b1, 63'd1}, MZ, 1'b0, 3'd0);
    check(fpsr_class == 4'b1000 && cr_value == exp_cr, "R3 R4 neg subnormal",
          {28'd0, fpsr_class, cr_value}, {28'd0, 4'b1000, exp_cr});

    // R11: reset mid-run clears everything
    rst_n = 1'b0;
    @(negedge clk);
    check(cr_value == '0 && fpsr_class == '0 && !flag_snan && !flag_vc, "R11 rerun",
          {flag_snan, flag_vc, fpsr_class, cr_value}, 64'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule